// File: doc/BRIEF.md
# Lockable Monitor Register File

A byte-wide bank of configuration and status registers for a fan-control and hardware-monitoring controller. A host reaches it through a flat port with an address, write data, a write strobe, a read strobe and registered read data. The converter, tachometer and PWM engines sit outside the block. They supply event inputs and take their settings from the configuration outputs.

Host writes pass through several layers of protection. A sticky lock bit freezes the start and lock bits, the fan-mode register, the PWM option registers and all duty-cycle registers. A duty-cycle register also accepts a write only while its fan is in manual mode. Low-power shutdown is in force when the low-power bit is 1 and start is 0. In shutdown only the control register and the three low bits of the special-function register can be reached. The override bit, the low-power bit and the interrupt-enable bit stay writable in every state.

Interrupt status bits capture events. Reading a status register clears the bits whose event is no longer active; a bit whose event is still active stays set. Unmapped addresses read 00h and ignore writes.

Top module: `lockable_regfile`

## Requirements
- R1: A read of an address outside the map (anything other than 30h–32h, 41h–42h, 5Fh, 7Ch, 7Fh, 90h–96h) returns 00h, and a write to such an address changes no register.
- R2: Fan-mode register 5Fh holds a manual flag per fan in bits [2:0]; its upper bits read 0. The duty register of fan i at 30h+i takes a write only when manual flag i is 1 and lock is 0.
- R3: Control register 7Fh has start in bit 0, lock in bit 1, override in bit 2 and low-power in bit 3; bits [7:4] read 0. Once lock is 1 it stays 1 until reset, and start and lock ignore writes.
- R4: Override and low-power take every write to 7Fh, whether or not lock or start is set.
- R5: Special-function register 7Ch is 8 bits of storage whose bit 0 is the interrupt enable (int_en_o); it is writable whether or not lock or start is set.
- R6: Event input j sets status bit j (register 41h bits [7:0] carry events 0–7, 42h bits [7:0] carry events 8–15). A status read returns the latched bits ORed with the live events, then clears the latched bits of that register whose event is inactive.
- R7: Shutdown (low-power 1, start 0): only 7Fh and bits [2:0] of 7Ch can be read or written. Other registers read 00h and keep their values, 7Ch bits [7:3] read 0 and keep their values, and status reads clear nothing.
- R8: After reset, tach option registers 90h–93h hold CCh, PWM option registers 94h–96h hold 0Ch, and every other register holds 00h.
- R9: PWM option registers 94h–96h store all eight bits, reserved bits [7:6] included, and ignore writes while lock is 1.
- R10: Read data appears on rdata_o one clock after the read strobe and holds until the next read. A cycle with both strobes is a write only, and rdata_o keeps its value.
- R11: Tach option registers 90h–93h are writable outside shutdown regardless of lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| evt_i | input | NUM_EVT | Live event inputs for the status registers |
| start_o | output | 1 | Start bit |
| lock_o | output | 1 | Lock bit |
| ovrd_o | output | 1 | Override bit |
| lpm_o | output | 1 | Low-power bit |
| int_en_o | output | 1 | Interrupt enable |
| sfr_o | output | 8 | Special-function register |
| fan_manual_o | output | NUM_FANS | Manual-mode flag per fan |
| duty_o | output | 8*NUM_FANS | Duty-cycle register per fan |
| pwm_opt_o | output | 8*NUM_FANS | PWM option register per fan |
| tach_opt_o | output | 8*NUM_TACH | Tach option register per tach input |

## Verification
Duty writes are tried on a fan with manual mode clear, on fans with it set, and again after lock. This separates the manual-mode gate from the lock gate. Status is driven with a one-cycle pulse and with a held event, and is read repeatedly. This separates clearing an inactive bit from keeping an active one, and checks that a drop of a held event stays latched until the next read. Shutdown is entered with start at 0, and the same writes and reads are repeated after start is set. This shows that the masking depends on the pair of bits and not on low-power alone. A behavioural model checks every output on every clock, so a write that slips past a gate shows up on the cycle it lands.

// File: rtl/lmrf_pkg.sv
package lmrf_pkg;
  typedef logic [7:0] byte_t;

  localparam byte_t ADDR_CTRL  = 8'h7F;
  localparam byte_t ADDR_SFR   = 8'h7C;
  localparam byte_t ADDR_FMODE = 8'h5F;

  localparam int CTRL_START = 0;
  localparam int CTRL_LOCK  = 1;
  localparam int CTRL_OVRD  = 2;
  localparam int CTRL_LPM   = 3;

  localparam int SFR_SD_BITS = 3;  // sfr bits reachable in shutdown

  localparam byte_t TACH_RST = 8'hCC;
  localparam byte_t POPT_RST = 8'h0C;
endpackage

// File: rtl/lmrf_ctrl.sv
module lmrf_ctrl
  import lmrf_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctrl_we_i,
  input  logic [3:0] ctrl_wd_i,
  input  logic       sfr_we_i,
  input  byte_t      sfr_wd_i,
  output logic       start_o,
  output logic       lock_o,
  output logic       ovrd_o,
  output logic       lpm_o,
  output byte_t      sfr_o,
  output logic       shutdown_o
);
  logic  start_q, lock_q, ovrd_q, lpm_q;
  byte_t sfr_q;

  assign shutdown_o = lpm_q & ~start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      lock_q  <= 1'b0;
      ovrd_q  <= 1'b0;
      lpm_q   <= 1'b0;
    end else if (ctrl_we_i) begin
      ovrd_q <= ctrl_wd_i[CTRL_OVRD];
      lpm_q  <= ctrl_wd_i[CTRL_LPM];
      if (!lock_q) begin
        start_q <= ctrl_wd_i[CTRL_START];
        lock_q  <= ctrl_wd_i[CTRL_LOCK];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sfr_q <= '0;
    end else if (sfr_we_i) begin
      if (shutdown_o) sfr_q[SFR_SD_BITS-1:0] <= sfr_wd_i[SFR_SD_BITS-1:0];
      else            sfr_q <= sfr_wd_i;
    end
  end

  assign start_o = start_q;
  assign lock_o  = lock_q;
  assign ovrd_o  = ovrd_q;
  assign lpm_o   = lpm_q;
  assign sfr_o   = sfr_q;

  a_r3_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q);
  a_r3_start_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> $stable(start_q));
  a_r4_ovrd_takes_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i |=> (ovrd_q == $past(ctrl_wd_i[CTRL_OVRD])));
  a_r7_sfr_high_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |=> $stable(sfr_q[7:SFR_SD_BITS]));
endmodule

// File: rtl/lmrf_fan.sv
module lmrf_fan
  import lmrf_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  duty_we_i,
  input  logic  opt_we_i,
  input  logic  manual_i,
  input  logic  lock_i,
  input  logic  shutdown_i,
  input  byte_t wd_i,
  output byte_t duty_o,
  output byte_t opt_o
);
  byte_t duty_q, opt_q;
  logic  duty_ok, opt_ok;

  assign opt_ok  = opt_we_i & ~lock_i & ~shutdown_i;
  assign duty_ok = duty_we_i & manual_i & ~lock_i & ~shutdown_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_q <= '0;
      opt_q  <= POPT_RST;
    end else begin
      if (duty_ok) duty_q <= wd_i;
      if (opt_ok)  opt_q  <= wd_i;
    end
  end

  assign duty_o = duty_q;
  assign opt_o  = opt_q;

  a_r2_duty_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!manual_i || lock_i) |=> $stable(duty_q));
  a_r9_opt_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> $stable(opt_q));
endmodule

// File: rtl/lmrf_status.sv
module lmrf_status #(
  parameter int NUM_EVT = 16,
  localparam int NREG   = (NUM_EVT + 7) / 8,
  localparam int W      = NREG * 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [NREG-1:0]    clr_i,
  output logic [W-1:0]       stat_o
);
  logic [W-1:0] evt_pad, stat_q, stat_d;

  assign evt_pad = W'(evt_i);

  // on a clearing read only still-active events survive
  always_comb begin
    for (int k = 0; k < NREG; k++) begin
      if (clr_i[k]) stat_d[k*8 +: 8] = evt_pad[k*8 +: 8];
      else          stat_d[k*8 +: 8] = stat_q[k*8 +: 8] | evt_pad[k*8 +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d;
  end

  assign stat_o = stat_q | evt_pad;

  a_r6_event_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_pad != '0) |=> ((stat_q & $past(evt_pad)) == $past(evt_pad)));
  a_r6_unread_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i == '0) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
endmodule

// File: rtl/lockable_regfile.sv
module lockable_regfile
  import lmrf_pkg::*;
#(
  parameter int NUM_FANS  = 3,
  parameter int NUM_TACH  = 4,
  parameter int NUM_EVT   = 16,
  parameter int DUTY_BASE = 8'h30,
  parameter int STAT_BASE = 8'h41,
  parameter int TACH_BASE = 8'h90,
  localparam int POPT_BASE = TACH_BASE + NUM_TACH,
  localparam int NSTAT     = (NUM_EVT + 7) / 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [7:0]            addr_i,
  input  logic [7:0]            wdata_i,
  input  logic                  wr_i,
  input  logic                  rd_i,
  output logic [7:0]            rdata_o,
  input  logic [NUM_EVT-1:0]    evt_i,
  output logic                  start_o,
  output logic                  lock_o,
  output logic                  ovrd_o,
  output logic                  lpm_o,
  output logic                  int_en_o,
  output logic [7:0]            sfr_o,
  output logic [NUM_FANS-1:0]   fan_manual_o,
  output logic [NUM_FANS*8-1:0] duty_o,
  output logic [NUM_FANS*8-1:0] pwm_opt_o,
  output logic [NUM_TACH*8-1:0] tach_opt_o
);
  logic rd_act, shutdown, mapped;
  logic ctrl_hit, sfr_hit, fmode_hit;
  logic [NUM_FANS-1:0] duty_hit, popt_hit;
  logic [NUM_TACH-1:0] tach_hit;
  logic [NSTAT-1:0]    stat_hit, stat_clr;
  logic [NSTAT*8-1:0]  stat_w;
  logic [NUM_FANS-1:0] manual_q;
  logic [NUM_TACH*8-1:0] tach_q;
  byte_t rd_val, rdata_q;

  assign rd_act    = rd_i & ~wr_i;  // write wins on a shared cycle
  assign ctrl_hit  = (addr_i == ADDR_CTRL);
  assign sfr_hit   = (addr_i == ADDR_SFR);
  assign fmode_hit = (addr_i == ADDR_FMODE);

  lmrf_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_we_i  (wr_i & ctrl_hit),
    .ctrl_wd_i  (wdata_i[3:0]),
    .sfr_we_i   (wr_i & sfr_hit),
    .sfr_wd_i   (wdata_i),
    .start_o    (start_o),
    .lock_o     (lock_o),
    .ovrd_o     (ovrd_o),
    .lpm_o      (lpm_o),
    .sfr_o      (sfr_o),
    .shutdown_o (shutdown)
  );

  assign int_en_o = sfr_o[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) manual_q <= '0;
    else if (wr_i && fmode_hit && !lock_o && !shutdown) manual_q <= wdata_i[NUM_FANS-1:0];
  end
  assign fan_manual_o = manual_q;

  for (genvar g = 0; g < NUM_FANS; g++) begin : g_fan
    assign duty_hit[g] = (addr_i == 8'(DUTY_BASE + g));
    assign popt_hit[g] = (addr_i == 8'(POPT_BASE + g));
    lmrf_fan u_fan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .duty_we_i  (wr_i & duty_hit[g]),
      .opt_we_i   (wr_i & popt_hit[g]),
      .manual_i   (manual_q[g]),
      .lock_i     (lock_o),
      .shutdown_i (shutdown),
      .wd_i       (wdata_i),
      .duty_o     (duty_o[g*8 +: 8]),
      .opt_o      (pwm_opt_o[g*8 +: 8])
    );
  end

  for (genvar g = 0; g < NUM_TACH; g++) begin : g_tach
    assign tach_hit[g] = (addr_i == 8'(TACH_BASE + g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tach_q[g*8 +: 8] <= TACH_RST;
      else if (wr_i && tach_hit[g] && !shutdown) tach_q[g*8 +: 8] <= wdata_i;
    end
  end
  assign tach_opt_o = tach_q;

  for (genvar k = 0; k < NSTAT; k++) begin : g_stat
    assign stat_hit[k] = (addr_i == 8'(STAT_BASE + k));
    assign stat_clr[k] = rd_act & stat_hit[k] & ~shutdown;
  end

  lmrf_status #(.NUM_EVT(NUM_EVT)) u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt_i),
    .clr_i  (stat_clr),
    .stat_o (stat_w)
  );

  assign mapped = ctrl_hit | sfr_hit | fmode_hit | (|duty_hit) | (|popt_hit)
                | (|tach_hit) | (|stat_hit);

  always_comb begin
    rd_val = '0;
    if (ctrl_hit) rd_val = {4'b0, lpm_o, ovrd_o, lock_o, start_o};
    if (sfr_hit)  rd_val = shutdown ? byte_t'(sfr_o[SFR_SD_BITS-1:0]) : sfr_o;
    if (!shutdown) begin
      if (fmode_hit) rd_val = byte_t'(manual_q);
      for (int i = 0; i < NUM_FANS; i++) begin
        if (duty_hit[i]) rd_val = duty_o[i*8 +: 8];
        if (popt_hit[i]) rd_val = pwm_opt_o[i*8 +: 8];
      end
      for (int i = 0; i < NUM_TACH; i++)
        if (tach_hit[i]) rd_val = tach_q[i*8 +: 8];
      for (int i = 0; i < NSTAT; i++)
        if (stat_hit[i]) rd_val = stat_w[i*8 +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (rd_act) rdata_q <= rd_val;
  end
  assign rdata_o = rdata_q;

  a_r1_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_act && !mapped) |=> (rdata_o == 8'h00));
  a_r10_write_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> $stable(rdata_o));
  a_r7_tach_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown |=> $stable(tach_q));
  a_r7_manual_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shutdown || lock_o) |=> $stable(manual_q));
endmodule

// File: tb/lockable_regfile_bench.sv
module lockable_regfile_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [7:0]  addr = '0, wdata = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] evt = '0;

  logic [7:0]  rdata_o, sfr_o;
  logic        start_o, lock_o, ovrd_o, lpm_o, int_en_o;
  logic [2:0]  fan_manual_o;
  logic [23:0] duty_o, pwm_opt_o;
  logic [31:0] tach_opt_o;

  lockable_regfile u_lockable_regfile (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr), .rd_i(rd),
    .rdata_o(rdata_o), .evt_i(evt), .start_o(start_o), .lock_o(lock_o), .ovrd_o(ovrd_o),
    .lpm_o(lpm_o), .int_en_o(int_en_o), .sfr_o(sfr_o), .fan_manual_o(fan_manual_o),
    .duty_o(duty_o), .pwm_opt_o(pwm_opt_o), .tach_opt_o(tach_opt_o)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference
  bit m_start, m_lock, m_ovrd, m_lpm;
  logic [7:0]  m_sfr, m_rdata;
  logic [2:0]  m_man;
  logic [15:0] m_stat;
  logic [7:0]  m_duty [3];
  logic [7:0]  m_popt [3];
  logic [7:0]  m_tach [4];

  function automatic logic [7:0] m_read(input logic [7:0] a);
    bit sd = m_lpm && !m_start;
    logic [7:0] v = 8'h00;
    if (a == 8'h7F) v = {4'b0, m_lpm, m_ovrd, m_lock, m_start};
    else if (a == 8'h7C) v = sd ? (m_sfr & 8'h07) : m_sfr;
    else if (!sd) begin
      if (a == 8'h5F) v = {5'b0, m_man};
      else if (a >= 8'h30 && a < 8'h33) v = m_duty[a - 8'h30];
      else if (a >= 8'h90 && a < 8'h94) v = m_tach[a - 8'h90];
      else if (a >= 8'h94 && a < 8'h97) v = m_popt[a - 8'h94];
      else if (a == 8'h41) v = m_stat[7:0] | evt[7:0];
      else if (a == 8'h42) v = m_stat[15:8] | evt[15:8];
    end
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_start = 0; m_lock = 0; m_ovrd = 0; m_lpm = 0;
      m_sfr = 0; m_rdata = 0; m_man = 0; m_stat = 0;
      for (int i = 0; i < 3; i++) begin m_duty[i] = 8'h00; m_popt[i] = 8'h0C; end
      for (int i = 0; i < 4; i++) m_tach[i] = 8'hCC;
    end else begin
      bit sd, lk;
      logic [7:0] rv;
      sd = m_lpm && !m_start;
      lk = m_lock;
      rv = m_read(addr);
      m_stat = m_stat | evt;
      if (wr) begin
        if (addr == 8'h7F) begin
          m_ovrd = wdata[2]; m_lpm = wdata[3];
          if (!lk) begin m_start = wdata[0]; m_lock = wdata[1]; end
        end else if (addr == 8'h7C) begin
          if (sd) m_sfr[2:0] = wdata[2:0]; else m_sfr = wdata;
        end else if (!sd) begin
          if (addr == 8'h5F && !lk) m_man = wdata[2:0];
          if (addr >= 8'h30 && addr < 8'h33 && m_man[addr - 8'h30] && !lk) m_duty[addr - 8'h30] = wdata;
          if (addr >= 8'h90 && addr < 8'h94) m_tach[addr - 8'h90] = wdata;
          if (addr >= 8'h94 && addr < 8'h97 && !lk) m_popt[addr - 8'h94] = wdata;
        end
      end else if (rd) begin
        m_rdata = rv;
        if (!sd && addr == 8'h41) m_stat[7:0]  = evt[7:0];
        if (!sd && addr == 8'h42) m_stat[15:8] = evt[15:8];
      end
    end
  end

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R10 rdata", rdata_o, m_rdata);
      chk("R3 ctrl bits", {start_o, lock_o, ovrd_o, lpm_o}, {m_start, m_lock, m_ovrd, m_lpm});
      chk("R5 sfr", {int_en_o, sfr_o}, {m_sfr[0], m_sfr});
      chk("R2 manual", fan_manual_o, m_man);
      chk("R2 duty", duty_o, {m_duty[2], m_duty[1], m_duty[0]});
      chk("R9 pwm opt", pwm_opt_o, {m_popt[2], m_popt[1], m_popt[0]});
      chk("R11 tach opt", tach_opt_o, {m_tach[3], m_tach[2], m_tach[1], m_tach[0]});
    end
  end

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1; rd = 1'b0;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, input logic [7:0] e, input string tag);
    @(negedge clk); addr = a; rd = 1'b1; wr = 1'b0;
    @(negedge clk); rd = 1'b0;
    chk(tag, rdata_o, e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 tach reset", tach_opt_o, 32'hCCCC_CCCC);
    chk("R8 pwm opt reset", pwm_opt_o, 24'h0C0C0C);
    chk("R8 duty reset", duty_o, 24'h0);
    chk("R8 rdata reset", rdata_o, 8'h00);

    rd_reg(8'h00, 8'h00, "R1 unmapped 00");
    rd_reg(8'hFF, 8'h00, "R1 unmapped FF");
    wr_reg(8'h00, 8'h5A);
    rd_reg(8'h00, 8'h00, "R1 unmapped write ignored");

    wr_reg(8'h30, 8'h80);
    rd_reg(8'h30, 8'h00, "R2 duty not manual");
    wr_reg(8'h5F, 8'hFD);
    rd_reg(8'h5F, 8'h05, "R2 fan mode");
    wr_reg(8'h30, 8'h80);
    wr_reg(8'h31, 8'h40);
    wr_reg(8'h32, 8'h20);
    rd_reg(8'h30, 8'h80, "R2 duty fan0 manual");
    rd_reg(8'h31, 8'h00, "R2 duty fan1 auto");
    rd_reg(8'h32, 8'h20, "R2 duty fan2 manual");

    wr_reg(8'h94, 8'hFF);
    rd_reg(8'h94, 8'hFF, "R9 reserved bits stored");
    wr_reg(8'h95, 8'hC3);
    rd_reg(8'h95, 8'hC3, "R9 pwm opt write");
    wr_reg(8'h92, 8'h11);
    rd_reg(8'h92, 8'h11, "R11 tach write");

    @(negedge clk); evt = 16'h0208;
    @(negedge clk); evt = 16'h0200;
    rd_reg(8'h41, 8'h08, "R6 pulse latched");
    rd_reg(8'h41, 8'h00, "R6 pulse cleared");
    rd_reg(8'h42, 8'h02, "R6 held event");
    rd_reg(8'h42, 8'h02, "R6 active survives read");
    @(negedge clk); evt = 16'h0000;
    rd_reg(8'h42, 8'h02, "R6 latched after drop");
    rd_reg(8'h42, 8'h00, "R6 cleared once inactive");

    @(negedge clk); addr = 8'h92; wdata = 8'h22; wr = 1'b1; rd = 1'b1;
    @(negedge clk); wr = 1'b0; rd = 1'b0;
    chk("R10 write wins rdata held", rdata_o, 8'h00);
    chk("R10 write wins data stored", tach_opt_o[23:16], 8'h22);

    wr_reg(8'h7C, 8'hA5);
    rd_reg(8'h7C, 8'hA5, "R5 sfr write");

    wr_reg(8'h7F, 8'h08);
    rd_reg(8'h7C, 8'h05, "R7 sfr masked");
    rd_reg(8'h92, 8'h00, "R7 tach hidden");
    wr_reg(8'h92, 8'h33);
    wr_reg(8'h7C, 8'hFA);
    @(negedge clk); evt = 16'h0001;
    @(negedge clk); evt = 16'h0000;
    rd_reg(8'h41, 8'h00, "R7 status hidden");
    wr_reg(8'h7F, 8'h01);
    rd_reg(8'h92, 8'h22, "R7 tach kept");
    rd_reg(8'h7C, 8'hA2, "R7 sfr low bits only");
    rd_reg(8'h41, 8'h01, "R7 status not cleared");
    wr_reg(8'h7F, 8'h09);
    rd_reg(8'h92, 8'h22, "R7 lpm with start not shutdown");

    wr_reg(8'h7F, 8'h03);
    wr_reg(8'h7F, 8'h00);
    rd_reg(8'h7F, 8'h03, "R3 lock holds start and lock");
    wr_reg(8'h7F, 8'h0C);
    rd_reg(8'h7F, 8'h0F, "R4 ovrd and lpm under lock");
    wr_reg(8'h7F, 8'h03);
    rd_reg(8'h7F, 8'h03, "R4 ovrd and lpm cleared");
    wr_reg(8'h30, 8'h11);
    rd_reg(8'h30, 8'h80, "R2 duty locked");
    wr_reg(8'h94, 8'h00);
    rd_reg(8'h94, 8'hFF, "R9 pwm opt locked");
    wr_reg(8'h5F, 8'h00);
    rd_reg(8'h5F, 8'h05, "R2 fan mode locked");
    wr_reg(8'h90, 8'h5A);
    rd_reg(8'h90, 8'h5A, "R11 tach under lock");
    wr_reg(8'h7C, 8'h01);
    rd_reg(8'h7C, 8'h01, "R5 int enable under lock");
    chk("R5 int_en_o", int_en_o, 1'b1);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule